// File: doc/BRIEF.md
# SMBus Slave Receive Byte Counter with Reload and PEC Check

This block tracks the data phase of an SMBus write in which this device is the target. A bit-level engine reports the matched address byte and then hands over each received byte in a single-cycle handshake. The block answers that handshake with an ACK or NACK decision in the same cycle, counts the byte against a software-programmed count, and raises a one-cycle receive-ready strobe carrying the byte. After the address match the bus is held (clock stretching requested) until software has programmed the count, the PEC-enable flag and the reload flag and has cleared the address flag.

When PEC is enabled and reload is off, the last byte of the programmed count is the packet error code. It is compared against a CRC-8 accumulated over the address byte and every data byte. A mismatch NACKs that byte and sets a sticky error flag. In reload mode the count is worked off in chunks: each time a chunk's count runs out, a transfer-complete-reload flag rises with the receive strobe and the bus is held until software writes a new count. This lets software choose ACK or NACK byte by byte. Software clears the reload flag when it writes the final chunk, so the last byte of that chunk is checked as the PEC. A STOP that arrives while bytes are still owed sets an early-stop flag.

Top module: `smb_rx_counter`

## Requirements
- R1: An address-match pulse sets the address flag, clears the count, the PEC and reload settings, the transfer-complete-reload flag, the NACK control, the PEC error and the early-stop flag. `stretch` is high while the address flag is set. A software address-clear drops the flag one cycle later.
- R2: Each byte accepted while the count is nonzero yields `rx_ready` high for exactly the following cycle, with `rx_data` equal to that byte, and lowers the count by one.
- R3: The PEC accumulator is a CRC-8 with polynomial 0x07 and initial value 0. It processes bits MSB first over the address byte and then every accepted byte that is not the PEC byte. The PEC byte is the byte that arrives when PEC is enabled, reload is off and the count equals 1. A PEC byte equal to the accumulator is ACKed (`rsp_nack` = 0).
- R4: With reload set, a byte that takes the count from 1 to 0 sets `tcr` in the same cycle that `rx_ready` rises. `tcr` holds `stretch` high until the next configuration write, which clears `tcr`.
- R5: During a byte handshake `rsp_nack` equals the NACK control bit. The bit is cleared by each byte handshake. A NACK-control write in the same cycle as a byte does not affect that byte and applies to the next one.
- R6: A PEC byte that differs from the accumulator gets `rsp_nack` = 1 and sets `pec_err`. The flag stays set until the next address match.
- R7: A byte arriving while the count is 0 gets `rsp_nack` = 1. It produces no `rx_ready` and leaves the count and accumulator untouched.
- R8: A STOP during an active transfer ends it. If bytes remain owed after counting any byte accepted in the same cycle, `early_stop` is set. A STOP together with the last owed byte does not set it.
- R9: With PEC disabled, the last byte of the count is plain data. It is ACKed whatever its value, unless the NACK control asks otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_match | input | 1 | Pulse: engine matched this device's address |
| addr_byte | input | 8 | Address byte including direction bit, valid with addr_match |
| sw_addr_clr | input | 1 | Software clears the address flag |
| sw_cfg_we | input | 1 | Software writes count, PEC enable and reload |
| sw_cnt | input | CNT_W | Byte count to load |
| sw_pec_en | input | 1 | Treat the last byte of the final chunk as PEC |
| sw_reload | input | 1 | Pause with tcr when the count expires |
| sw_nack_we | input | 1 | Software writes the NACK control bit |
| sw_nack_val | input | 1 | Value written to the NACK control bit (1 = NACK) |
| byte_valid | input | 1 | Engine presents a received byte at the acknowledge slot |
| byte_data | input | 8 | Received byte |
| stop_seen | input | 1 | Pulse: STOP condition detected |
| rsp_nack | output | 1 | Acknowledge decision for the byte presented (1 = NACK) |
| rx_ready | output | 1 | One-cycle strobe: a byte is available |
| rx_data | output | 8 | Last accepted byte |
| addr_flag | output | 1 | Address match pending software service |
| tcr | output | 1 | Count expired in reload mode, waiting for a new count |
| stretch | output | 1 | Request to hold the clock low |
| pec_err | output | 1 | PEC mismatch seen in this transfer |
| early_stop | output | 1 | STOP arrived with bytes still owed |

## Verification
Two pairs of events can share a cycle. A software NACK-control write can coincide with a byte handshake, and a STOP can coincide with the last owed byte. The bench drives both pairs in one cycle. It expects the byte to be answered with the old NACK value and the written value to govern the next byte. It expects the STOP to see the count after the byte is taken, so no early-stop flag rises. A behavioural reference model, advanced on every clock, judges all outputs against these orderings.

// File: rtl/smb_rx_pkg.sv
package smb_rx_pkg;
  // One CRC-8 update over a byte, fed one bit at a time, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/smb_rx_pec.sv
module smb_rx_pec #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed,
  input  logic [7:0] seed_byte,
  input  logic       take,
  input  logic [7:0] din,
  output logic       match
);
  import smb_rx_pkg::*;

  logic [7:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (seed) acc <= crc8_step(8'h00, seed_byte, POLY);
    else if (take) acc <= crc8_step(acc, din, POLY);
  end

  assign match = (din == acc);

  // R3: the accumulator only moves on a seed or on an accepted data byte
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed && !take) |=> $stable(acc));
endmodule

// File: rtl/smb_rx_count.sv
module smb_rx_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_match,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             cfg_pec_en,
  input  logic             cfg_reload,
  input  logic             byte_valid,
  output logic             byte_take,
  output logic             cnt_zero,
  output logic             is_pec,
  output logic             remain_nz,
  output logic             tcr
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             pec_en;
  logic             reload;
  logic             last_of_chunk;

  assign cnt_zero      = (cnt == '0);
  assign byte_take     = byte_valid && !cnt_zero;
  assign last_of_chunk = (cnt == ONE);
  assign is_pec        = pec_en && !reload && last_of_chunk;
  assign remain_nz     = byte_take ? !last_of_chunk : !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pec_en <= 1'b0;
      reload <= 1'b0;
      tcr    <= 1'b0;
    end else if (addr_match) begin
      cnt    <= '0;
      pec_en <= 1'b0;
      reload <= 1'b0;
      tcr    <= 1'b0;
    end else if (cfg_we) begin
      cnt    <= cfg_cnt;
      pec_en <= cfg_pec_en;
      reload <= cfg_reload;
      tcr    <= 1'b0;
    end else if (byte_take) begin
      cnt <= cnt - ONE;
      if (reload && last_of_chunk) tcr <= 1'b1;
    end
  end

  // R2: an accepted byte lowers the count by exactly one
  a_r2_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !cfg_we && !addr_match) |=> (cnt == $past(cnt) - ONE));
  // R7: a byte with no count left leaves the count at zero
  a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && cnt_zero && !cfg_we && !addr_match) |=> cnt_zero);
  // R4: tcr only rises from a byte that used up a reload chunk
  a_r4_tcr_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcr) |-> ($past(byte_take) && $past(reload)));
endmodule

// File: rtl/smb_rx_status.sv
module smb_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_match,
  input  logic       addr_clr,
  input  logic       nack_we,
  input  logic       nack_val,
  input  logic       byte_valid,
  input  logic       byte_take,
  input  logic [7:0] byte_data,
  input  logic       pec_fail,
  input  logic       stop_seen,
  input  logic       remain_nz,
  output logic       nack_ctrl,
  output logic       addr_flag,
  output logic       pec_err,
  output logic       early_stop,
  output logic       rx_ready,
  output logic [7:0] rx_data
);
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_ctrl  <= 1'b0;
      addr_flag  <= 1'b0;
      pec_err    <= 1'b0;
      early_stop <= 1'b0;
      active     <= 1'b0;
    end else if (addr_match) begin
      nack_ctrl  <= 1'b0;
      addr_flag  <= 1'b1;
      pec_err    <= 1'b0;
      early_stop <= 1'b0;
      active     <= 1'b1;
    end else begin
      if (nack_we)         nack_ctrl <= nack_val;
      else if (byte_valid) nack_ctrl <= 1'b0;
      if (addr_clr) addr_flag <= 1'b0;
      if (pec_fail) pec_err <= 1'b1;
      if (stop_seen) begin
        active <= 1'b0;
        if (active && remain_nz) early_stop <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_ready <= byte_take;
      if (byte_take) rx_data <= byte_data;
    end
  end

  // R6: the PEC error flag is sticky until an address match
  a_r6_pec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err && !addr_match) |=> pec_err);
  // R2: every accepted byte is followed by a ready strobe
  a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> rx_ready);
  // R8: early stop only rises on a STOP
  a_r8_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_stop) |-> $past(stop_seen));
endmodule

// File: rtl/smb_rx_counter.sv
module smb_rx_counter #(
  parameter int         CNT_W = 8,
  parameter logic [7:0] POLY  = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_match,
  input  logic [7:0]       addr_byte,
  input  logic             sw_addr_clr,
  input  logic             sw_cfg_we,
  input  logic [CNT_W-1:0] sw_cnt,
  input  logic             sw_pec_en,
  input  logic             sw_reload,
  input  logic             sw_nack_we,
  input  logic             sw_nack_val,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             stop_seen,
  output logic             rsp_nack,
  output logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             addr_flag,
  output logic             tcr,
  output logic             stretch,
  output logic             pec_err,
  output logic             early_stop
);
  // Named internal events, used by assertions below.
  logic byte_take;
  logic cnt_zero;
  logic is_pec;
  logic remain_nz;
  logic pec_match;
  logic pec_fail;
  logic nack_ctrl;
  logic acc_take;

  assign acc_take = byte_take && !is_pec;
  assign pec_fail = byte_take && is_pec && !pec_match;

  smb_rx_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_match (addr_match),
    .cfg_we     (sw_cfg_we),
    .cfg_cnt    (sw_cnt),
    .cfg_pec_en (sw_pec_en),
    .cfg_reload (sw_reload),
    .byte_valid (byte_valid),
    .byte_take  (byte_take),
    .cnt_zero   (cnt_zero),
    .is_pec     (is_pec),
    .remain_nz  (remain_nz),
    .tcr        (tcr)
  );

  smb_rx_pec #(.POLY(POLY)) u_pec (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (addr_match),
    .seed_byte (addr_byte),
    .take      (acc_take),
    .din       (byte_data),
    .match     (pec_match)
  );

  smb_rx_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_match (addr_match),
    .addr_clr   (sw_addr_clr),
    .nack_we    (sw_nack_we),
    .nack_val   (sw_nack_val),
    .byte_valid (byte_valid),
    .byte_take  (byte_take),
    .byte_data  (byte_data),
    .pec_fail   (pec_fail),
    .stop_seen  (stop_seen),
    .remain_nz  (remain_nz),
    .nack_ctrl  (nack_ctrl),
    .addr_flag  (addr_flag),
    .pec_err    (pec_err),
    .early_stop (early_stop),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data)
  );

  assign rsp_nack = byte_valid && (nack_ctrl || cnt_zero || pec_fail);
  assign stretch  = addr_flag || tcr;

  // R1: the bus is held while the address flag is pending
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_flag |-> stretch);
  // R4: the bus is held while a reload is pending
  a_r4_tcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tcr |-> stretch);
  // R7: a byte with no count left is refused
  a_r7_zero_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && cnt_zero) |-> rsp_nack);
  // R6: a failing PEC byte is refused and flagged
  a_r6_fail_nack: assert property (@(posedge clk) disable iff (!rst_n)
    pec_fail |-> (rsp_nack ##1 pec_err));
  // R3: a matching PEC byte is ACKed unless software asked for NACK
  a_r3_match_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && is_pec && pec_match && !nack_ctrl) |-> !rsp_nack);
endmodule

// File: tb/tb_smb_rx_counter.sv
`timescale 1ns/1ps
module tb_smb_rx_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_match = 0;
  logic [7:0] addr_byte = 0;
  logic       sw_addr_clr = 0;
  logic       sw_cfg_we = 0;
  logic [7:0] sw_cnt = 0;
  logic       sw_pec_en = 0;
  logic       sw_reload = 0;
  logic       sw_nack_we = 0;
  logic       sw_nack_val = 0;
  logic       byte_valid = 0;
  logic [7:0] byte_data = 0;
  logic       stop_seen = 0;
  logic       rsp_nack, rx_ready, addr_flag, tcr, stretch, pec_err, early_stop;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  smb_rx_counter dut (.*);

  // ---------------- reference model ----------------
  int       m_cnt;
  bit       m_pec_en, m_reload, m_tcr, m_addrf, m_nack, m_active;
  bit       m_rdy, m_perr, m_estop;
  bit [7:0] m_data, m_crc;

  // CRC-8, poly x^8+x^2+x+1, whole-byte xor then shift
  function automatic bit [7:0] ref_crc(bit [7:0] c, bit [7:0] d);
    bit [7:0] r = c ^ d;
    repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic bit m_is_pec();
    return m_pec_en && !m_reload && m_cnt == 1;
  endfunction

  function automatic bit m_exp_nack();
    if (!byte_valid) return 0;
    if (m_nack || m_cnt == 0) return 1;
    return m_is_pec() && (byte_data != m_crc);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pec_en = 0; m_reload = 0; m_tcr = 0; m_addrf = 0;
      m_nack = 0; m_active = 0; m_rdy = 0; m_perr = 0; m_estop = 0;
      m_data = 0; m_crc = 0;
    end else begin
      bit take, pec, fail;
      int rem;
      take = byte_valid && m_cnt != 0;
      pec  = m_is_pec();
      fail = take && pec && (byte_data != m_crc);
      rem  = take ? m_cnt - 1 : m_cnt;
      m_rdy = take;
      if (take) m_data = byte_data;
      if (addr_match) begin
        m_cnt = 0; m_pec_en = 0; m_reload = 0; m_tcr = 0; m_addrf = 1;
        m_nack = 0; m_active = 1; m_perr = 0; m_estop = 0;
        m_crc = ref_crc(8'h00, addr_byte);
      end else begin
        if (sw_cfg_we) begin
          m_cnt = sw_cnt; m_pec_en = sw_pec_en; m_reload = sw_reload; m_tcr = 0;
        end else if (take) begin
          if (m_reload && m_cnt == 1) m_tcr = 1;
          m_cnt = m_cnt - 1;
        end
        if (take && !pec) m_crc = ref_crc(m_crc, byte_data);
        if (sw_nack_we) m_nack = sw_nack_val;
        else if (byte_valid) m_nack = 0;
        if (sw_addr_clr) m_addrf = 0;
        if (fail) m_perr = 1;
        if (stop_seen) begin
          if (m_active && rem != 0) m_estop = 1;
          m_active = 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk(rx_ready == m_rdy, "R2", "rx_ready", rx_ready, m_rdy);
    chk(rx_data == m_data, "R2", "rx_data", rx_data, m_data);
    chk(addr_flag == m_addrf, "R1", "addr_flag", addr_flag, m_addrf);
    chk(tcr == m_tcr, "R4", "tcr", tcr, m_tcr);
    chk(stretch == (m_addrf || m_tcr), "R4", "stretch", stretch, m_addrf || m_tcr);
    chk(pec_err == m_perr, "R6", "pec_err", pec_err, m_perr);
    chk(early_stop == m_estop, "R8", "early_stop", early_stop, m_estop);
  endtask

  // Inputs are set at a falling edge; tick checks the combinational answer,
  // crosses one rising edge, checks registers and idles the inputs.
  task automatic tick();
    #1;
    if (byte_valid) chk(rsp_nack == m_exp_nack(), tag, "rsp_nack", rsp_nack, m_exp_nack());
    @(negedge clk);
    check_regs();
    addr_match = 0; sw_addr_clr = 0; sw_cfg_we = 0; sw_nack_we = 0;
    byte_valid = 0; stop_seen = 0;
  endtask

  task automatic do_addr(bit [7:0] a);
    addr_match = 1; addr_byte = a; tick();
  endtask
  task automatic do_cfg(int n, bit p, bit r);
    sw_cfg_we = 1; sw_cnt = 8'(n); sw_pec_en = p; sw_reload = r; tick();
  endtask
  task automatic do_clr();
    sw_addr_clr = 1; tick();
  endtask
  task automatic do_byte(bit [7:0] d);
    byte_valid = 1; byte_data = d; tick(); tick();
  endtask
  task automatic do_nack(bit v);
    sw_nack_we = 1; sw_nack_val = v; tick();
  endtask

  initial begin
    bit [7:0] pec;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_regs();
    rst_n = 1;
    @(negedge clk);
    check_regs();

    // R1, R2, R3: two data bytes plus a correct PEC, no reload
    tag = "R3";
    do_addr(8'hA6);
    chk(stretch == 1, "R1", "stretch after match", stretch, 1);
    do_cfg(3, 1, 0);
    do_clr();
    chk(stretch == 0, "R1", "stretch after clear", stretch, 0);
    pec = ref_crc(ref_crc(ref_crc(8'h00, 8'hA6), 8'h3C), 8'hF1);
    do_byte(8'h3C); do_byte(8'hF1); do_byte(pec);
    chk(pec_err == 0, "R3", "pec_err on good PEC", pec_err, 0);

    // R6: wrong PEC byte
    tag = "R6";
    do_addr(8'hA6); do_cfg(2, 1, 0); do_clr();
    pec = ref_crc(ref_crc(8'h00, 8'hA6), 8'h55);
    do_byte(8'h55); do_byte(pec ^ 8'h10);
    chk(pec_err == 1, "R6", "pec_err on bad PEC", pec_err, 1);
    tick(); tick();
    chk(pec_err == 1, "R6", "pec_err sticky", pec_err, 1);

    // R7: byte with count exhausted
    tag = "R7";
    do_byte(8'h99);
    chk(rx_ready == 0, "R7", "no ready on overrun", rx_ready, 0);

    // R4, R5: reload chunks of one byte each, PEC in last chunk
    tag = "R4";
    do_addr(8'h40); do_cfg(1, 1, 1); do_clr();
    pec = ref_crc(ref_crc(ref_crc(8'h00, 8'h40), 8'h12), 8'h34);
    byte_valid = 1; byte_data = 8'h12; tick();
    chk(tcr == 1 && rx_ready == 1, "R4", "tcr with ready", tcr, 1);
    tick(); tick();
    chk(stretch == 1, "R4", "stretch while tcr", stretch, 1);
    tag = "R5";
    do_nack(0); do_cfg(1, 1, 1);
    chk(tcr == 0, "R4", "tcr cleared by cfg", tcr, 0);
    do_byte(8'h34);
    do_cfg(1, 1, 0);
    tag = "R3";
    do_byte(pec);
    chk(pec_err == 0, "R3", "PEC after reload", pec_err, 0);

    // R5: NACK control, auto-clear, and write colliding with a byte
    tag = "R5";
    do_addr(8'h22); do_cfg(5, 0, 0); do_clr();
    do_nack(1);
    do_byte(8'h01);            // NACKed
    do_byte(8'h02);            // ACK again after auto-clear
    sw_nack_we = 1; sw_nack_val = 1; byte_valid = 1; byte_data = 8'h03;
    tick(); tick();            // this byte ACKed, write lands for next
    do_byte(8'h04);            // NACKed

    // R9: PEC disabled, last byte is data whatever its value
    tag = "R9";
    do_byte(8'hEE);
    chk(pec_err == 0, "R9", "no PEC check when disabled", pec_err, 0);

    // R8: STOP with bytes owed, and STOP together with the last byte
    tag = "R8";
    do_addr(8'h10); do_cfg(3, 0, 0); do_clr();
    do_byte(8'hAA);
    stop_seen = 1; tick();
    chk(early_stop == 1, "R8", "early stop", early_stop, 1);
    do_addr(8'h10); do_cfg(2, 0, 0); do_clr();
    do_byte(8'hAB);
    byte_valid = 1; byte_data = 8'hAC; stop_seen = 1; tick(); tick();
    chk(early_stop == 0, "R8", "stop with last byte", early_stop, 0);

    // R1: new match clears the transfer status
    tag = "R1";
    do_addr(8'h10);
    chk(early_stop == 0 && pec_err == 0, "R1", "status cleared", early_stop, 0);
    do_clr();
    repeat (3) tick();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule